// File: doc/BRIEF.md
# Programmable System Clock Ratio Divider

This block runs entirely in one fast core clock domain. From it, the block derives enable pulses for a high-speed bus clock and a peripheral bus clock. Each enable is a single-cycle pulse, high once per derived period. The core-to-bus ratio can be 1, 2, 3, 4, 6 or 8. The peripheral clock runs either at the bus rate or at half of it.

The block also reports whether the core runs from the fast clock or from the bus clock, and whether the bus runs in synchronous or asynchronous mode. It can halve a stream of USB-side clock ticks.

Software programs two registers through a write port: a control word and an auxiliary word. The ratio in force is reported back as plain binary divisors. A newly written ratio is held in shadow registers. It is applied only where the bus period and the peripheral period both start, so no derived period is ever cut short.

Top module: `sysclk_ratio_div`

## Requirements
- R1: The control word (wr_sel=0) holds the bus divide code in bits 2:1. Code 0 gives a bus enable on every cycle, code 1 gives one every 2 cycles, and code 2 gives one every 4 cycles.
- R2: When the bus code is 2 and auxiliary word (wr_sel=1) bit 9 is set, the bus enable period becomes 8 cycles.
- R3: When the bus code is 3, the bus enable period is 3 cycles, or 6 cycles when auxiliary bit 8 is set.
- R4: When control bit 0 is 1, per_en_o pulses on every second bus pulse, and always together with a bus pulse. When control bit 0 is 0, per_en_o equals bus_en_o. per_div_o reads 2 or 1 to match.
- R5: When auxiliary bit 12 is set, cpu_src_bus_o is 1 and cpu_en_o follows bus_en_o. Otherwise cpu_src_bus_o is 0 and cpu_en_o is 1 on every cycle out of reset.
- R6: When control bit 3 is set, usb_tick_o passes only every second input tick, starting with the first one. When bit 3 is clear, each tick passes through one cycle later.
- R7: async_bus_o is 0 only while the bus code in force is 0.
- R8: A written ratio takes effect only at a cycle where a bus pulse and a peripheral pulse start together. The spacing between consecutive bus pulses always equals the divisor reported during the earlier period.
- R9: Synchronous active-high reset clears both registers. After reset, bus_div_o=1, per_div_o=1 and async_bus_o=0, and all enables are low while reset is held.
- R10: bus_div_o reports the bus divisor in force, from 1 to 8. It changes in the same cycle as the first bus pulse of the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast core clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the auxiliary word |
| wr_data | input | 16 | write data |
| usb_tick_i | input | 1 | USB-side clock tick input |
| bus_en_o | output | 1 | bus clock enable pulse |
| per_en_o | output | 1 | peripheral clock enable pulse |
| cpu_en_o | output | 1 | core clock enable |
| cpu_src_bus_o | output | 1 | core is sourced from the bus clock |
| usb_tick_o | output | 1 | USB-side tick, optionally halved |
| async_bus_o | output | 1 | asynchronous bus mode indication |
| bus_div_o | output | 4 | bus divisor in force |
| per_div_o | output | 2 | peripheral divisor in force (1 or 2) |

## Verification
A register write and a ratio boundary can land on the same cycle. In that case the boundary must load the value that was in the shadow registers before the write. The bench provokes this by writing new ratios back to back at several phase offsets, including the cycle where a combined pulse is due. Every output is then compared cycle by cycle with a behavioural model. Each gap between bus pulses is also measured against the divisor read back during the earlier period.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int REG_W     = 16;
  localparam int DIV_W     = 4;
  localparam int PDIV_W    = 2;
  localparam int CTL_PER   = 0;
  localparam int CTL_CODE  = 1;
  localparam int CTL_USB   = 3;
  localparam int AUX_SIX   = 8;
  localparam int AUX_EIGHT = 9;
  localparam int AUX_CORE  = 12;

  typedef struct packed {
    logic [1:0] code;
    logic       per_half;
    logic       usb_half;
    logic       six;
    logic       eight;
    logic       core_bus;
  } ratio_cfg_t;

  function automatic logic [DIV_W-1:0] bus_divisor(ratio_cfg_t c);
    case (c.code)
      2'd0:    bus_divisor = DIV_W'(1);
      2'd1:    bus_divisor = DIV_W'(2);
      2'd2:    bus_divisor = c.eight ? DIV_W'(8) : DIV_W'(4);
      default: bus_divisor = c.six   ? DIV_W'(6) : DIV_W'(3);
    endcase
  endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import sclk_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output ratio_cfg_t   cfg_o
);
  logic [W-1:0] ctl_q, aux_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      aux_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) aux_q <= wr_data;
      else        ctl_q <= wr_data;
    end
  end

  always_comb begin
    cfg_o.code     = ctl_q[CTL_CODE +: 2];
    cfg_o.per_half = ctl_q[CTL_PER];
    cfg_o.usb_half = ctl_q[CTL_USB];
    cfg_o.six      = aux_q[AUX_SIX];
    cfg_o.eight    = aux_q[AUX_EIGHT];
    cfg_o.core_bus = aux_q[AUX_CORE];
  end
endmodule

// File: rtl/cdiv_engine.sv
module cdiv_engine
  import sclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ratio_cfg_t        cfg_i,
  output logic              bus_en_o,
  output logic              per_en_o,
  output logic              cpu_en_o,
  output logic              core_bus_o,
  output logic              async_o,
  output logic [DIV_W-1:0]  bdiv_o,
  output logic [PDIV_W-1:0] pdiv_o
);
  ratio_cfg_t        eff_q;
  logic [DIV_W-1:0]  bdiv_q, cnt_q, nb;
  logic [PDIV_W-1:0] pdiv_q, np;
  logic              ph_q, hit, bnd;

  assign hit = (cnt_q == '0);
  assign bnd = hit && !ph_q;
  assign nb  = bus_divisor(cfg_i);
  assign np  = cfg_i.per_half ? PDIV_W'(2) : PDIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q    <= '0;
      bdiv_q   <= DIV_W'(1);
      pdiv_q   <= PDIV_W'(1);
      cnt_q    <= '0;
      ph_q     <= 1'b0;
      bus_en_o <= 1'b0;
      per_en_o <= 1'b0;
      cpu_en_o <= 1'b0;
    end else begin
      bus_en_o <= hit;
      per_en_o <= bnd;
      cpu_en_o <= eff_q.core_bus ? hit : 1'b1;
      if (bnd) begin
        eff_q  <= cfg_i;
        bdiv_q <= nb;
        pdiv_q <= np;
        cnt_q  <= (nb == DIV_W'(1)) ? '0 : DIV_W'(1);
        ph_q   <= (np == PDIV_W'(2));
      end else if (hit) begin
        cnt_q  <= (bdiv_q == DIV_W'(1)) ? '0 : DIV_W'(1);
        ph_q   <= 1'b0;
      end else begin
        cnt_q  <= (cnt_q + DIV_W'(1) == bdiv_q) ? '0 : cnt_q + DIV_W'(1);
      end
    end
  end

  assign bdiv_o     = bdiv_q;
  assign pdiv_o     = pdiv_q;
  assign async_o    = (eff_q.code != 2'd0);
  assign core_bus_o = eff_q.core_bus;

  // R4
  per_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    per_en_o |-> bus_en_o);
  // R8
  ratio_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bdiv_q) |-> bus_en_o && per_en_o);
  // R7
  async_mode_chk: assert property (@(posedge clk) disable iff (rst)
    async_o == (bdiv_o != DIV_W'(1)));
  // R5
  cpu_follow_chk: assert property (@(posedge clk) disable iff (rst)
    core_bus_o |-> (cpu_en_o == bus_en_o));
endmodule

// File: rtl/cdiv_usb.sv
module cdiv_usb (
  input  logic clk,
  input  logic rst,
  input  logic half_i,
  input  logic tick_i,
  output logic tick_o
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= tick_i && (!half_i || !ph_q);
      if (!half_i)     ph_q <= 1'b0;
      else if (tick_i) ph_q <= ~ph_q;
    end
  end

  // R6
  usb_pass_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(tick_i));
endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
  import sclk_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              usb_tick_i,
  output logic              bus_en_o,
  output logic              per_en_o,
  output logic              cpu_en_o,
  output logic              cpu_src_bus_o,
  output logic              usb_tick_o,
  output logic              async_bus_o,
  output logic [DIV_W-1:0]  bus_div_o,
  output logic [PDIV_W-1:0] per_div_o
);
  ratio_cfg_t cfg;

  cdiv_regs #(.W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_o(cfg)
  );

  cdiv_engine u_engine (
    .clk(clk), .rst(rst), .cfg_i(cfg),
    .bus_en_o(bus_en_o), .per_en_o(per_en_o), .cpu_en_o(cpu_en_o),
    .core_bus_o(cpu_src_bus_o), .async_o(async_bus_o),
    .bdiv_o(bus_div_o), .pdiv_o(per_div_o)
  );

  cdiv_usb u_usb (
    .clk(clk), .rst(rst), .half_i(cfg.usb_half),
    .tick_i(usb_tick_i), .tick_o(usb_tick_o)
  );
endmodule

// File: tb/sim_sysclk_ratio_div.sv
module sim_sysclk_ratio_div;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_sel = 1'b0, usb_i = 1'b0;
  logic [15:0] wr_data = '0;
  logic        bus_en, per_en, cpu_en, cpu_src, usb_o, async_b;
  logic [3:0]  bus_div;
  logic [1:0]  per_div;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural model state
  int  sh_code, ef_code, ef_b, ef_p, pos, pc, uph;
  bit  sh_per, sh_usb, sh_six, sh_eight, sh_core, ef_core, hit, bnd;
  bit  e_bus, e_per, e_cpu, e_usb;
  int  gap = 0, prev_div = 0;
  bit  have_prev = 0;

  always #5 clk = ~clk;

  sysclk_ratio_div u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .usb_tick_i(usb_i), .bus_en_o(bus_en), .per_en_o(per_en), .cpu_en_o(cpu_en),
    .cpu_src_bus_o(cpu_src), .usb_tick_o(usb_o), .async_bus_o(async_b),
    .bus_div_o(bus_div), .per_div_o(per_div)
  );

  function automatic int bdiv_of(int code, bit six, bit eight);
    case (code)
      0: return 1;
      1: return 2;
      2: return eight ? 8 : 4;
      default: return six ? 6 : 3;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      sh_code = 0; sh_per = 0; sh_usb = 0; sh_six = 0; sh_eight = 0; sh_core = 0;
      ef_code = 0; ef_core = 0; ef_b = 1; ef_p = 1; pos = 0; pc = 0; uph = 0;
      e_bus = 0; e_per = 0; e_cpu = 0; e_usb = 0;
    end else begin
      hit = (pos == 0);
      bnd = hit && (pc == 0);
      e_bus = hit;
      e_per = bnd;
      e_cpu = ef_core ? hit : 1'b1;
      if (sh_usb) begin
        e_usb = usb_i && (uph == 0);
        if (usb_i) uph = 1 - uph;
      end else begin
        e_usb = usb_i;
        uph = 0;
      end
      if (bnd) begin
        ef_code = sh_code; ef_core = sh_core;
        ef_b = bdiv_of(sh_code, sh_six, sh_eight);
        ef_p = sh_per ? 2 : 1;
        pos = 1 % ef_b;
        pc = (ef_p == 2) ? 1 : 0;
      end else if (hit) begin
        pos = 1 % ef_b;
        pc = 0;
      end else begin
        pos = (pos + 1) % ef_b;
      end
      if (wr_en) begin
        if (!wr_sel) begin
          sh_per = wr_data[0]; sh_code = int'(wr_data[2:1]); sh_usb = wr_data[3];
        end else begin
          sh_six = wr_data[8]; sh_eight = wr_data[9]; sh_core = wr_data[12];
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk("R1 bus_en", int'(bus_en), int'(e_bus));
      chk("R4 per_en", int'(per_en), int'(e_per));
      chk("R5 cpu_en", int'(cpu_en), int'(e_cpu));
      chk("R5 cpu_src", int'(cpu_src), rst ? 0 : int'(ef_core));
      chk("R6 usb_tick", int'(usb_o), int'(e_usb));
      chk("R7 async", int'(async_b), rst ? 0 : int'(ef_code != 0));
      chk("R10 bus_div", int'(bus_div), rst ? 1 : ef_b);
      chk("R4 per_div", int'(per_div), rst ? 1 : ef_p);
      if (rst) begin
        have_prev = 0; gap = 0;
      end else begin
        gap++;
        if (bus_en) begin
          if (have_prev) chk("R8 pulse gap", gap, prev_div);
          prev_div = int'(bus_div);
          have_prev = 1;
          gap = 0;
        end
      end
      usb_i <= (cyc % 3) != 1;
    end
  end

  task automatic wr(bit sel, logic [15:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_sel <= sel; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 bus_div", int'(bus_div), 1);
    chk("R9 per_div", int'(per_div), 1);
    chk("R9 bus_en", int'(bus_en), 0);
    chk("R9 async", int'(async_b), 0);
    rst <= 1'b0;
    run(10);
    chk("R1 ratio 1", int'(bus_div), 1);
    wr(1'b0, 16'h0002); run(20);
    chk("R1 ratio 2", int'(bus_div), 2);
    wr(1'b0, 16'h0004); run(30);
    chk("R1 ratio 4", int'(bus_div), 4);
    wr(1'b1, 16'h0200); run(40);
    chk("R2 ratio 8", int'(bus_div), 8);
    wr(1'b0, 16'h0007); run(40);
    chk("R3 ratio 3", int'(bus_div), 3);
    chk("R4 per div 2", int'(per_div), 2);
    wr(1'b1, 16'h0100); run(50);
    chk("R3 ratio 6", int'(bus_div), 6);
    wr(1'b1, 16'h1100); run(40);
    chk("R5 core src", int'(cpu_src), 1);
    wr(1'b0, 16'h0008); run(30);
    chk("R7 sync mode", int'(async_b), 0);
    wr(1'b1, 16'h0000); run(20);
    // R8 back-to-back rewrites at varied phases
    for (int k = 0; k < 12; k++) begin
      wr(1'b0, 16'(((k % 4) << 1) | (k & 1)));
      run(k % 5);
      wr(1'b1, (k % 3 == 0) ? 16'h0300 : 16'h1000);
      run(k % 7);
    end
    run(60);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule